// File: doc/BRIEF.md
# Dual-Stage Integer Min/Max Unit

This unit executes one packed-video style min/max instruction per clock. An instruction word and three register operands are accepted when the input valid is high. A primary stage picks the smaller or larger of operands A and B. Its comparison is either signed or unsigned. A secondary stage then combines that value with operand C. It can write the value into one byte or halfword lane of C, add it to C, run a second min/max against C with its own signedness control, or pass it through unchanged.

The result is registered. It appears together with an output valid exactly one cycle after the inputs are taken. Only one subset of the encoding is fully handled: register-sourced B, full-width sources, matched source signedness, no saturation and no condition-code write. For any other encoding the unit raises a flag next to the result. The value is still produced by the supported path, so the surrounding pipeline can decide whether to trap or accept it.

Top module: `dual_minmax_unit`

## Requirements
- R1: The instruction is recognised only when bits 63..57 equal 0011101; any other value there (including 0011100, the immediate conversion form) makes `unsupported` high with the result.
- R2: Control fields are taken from fixed positions: bit 56 picks max (1) or min (0), bit 55 saturate, bit 54 secondary signedness, bits 53..51 secondary code, bit 50 B-from-register, bit 49 B signed, bit 48 A signed, bit 47 condition-code write, bits 38..37 and 30..29 the A and B formats (11 = 32-bit); all other bits have no effect on the result.
- R3: The primary stage yields max(A,B) when bit 56 is 1 and min(A,B) when it is 0, compared as two's-complement when bit 48 is 1 and as unsigned otherwise.
- R4: Secondary codes 0..3 write the primary value into a lane of C: code 0 puts its low 16 bits in 31..16, code 1 its low 16 bits in 15..0, code 2 its low 8 bits in 7..0, code 3 its low 8 bits in 23..16; every bit of C outside the lane reaches the result unchanged.
- R5: Secondary code 4 yields the primary value plus C, modulo 2^32.
- R6: Secondary code 5 yields the minimum and code 6 the maximum of the primary value and C, signed when bit 54 is 1 and unsigned otherwise.
- R7: Secondary code 7 yields the primary value unchanged.
- R8: `unsupported` is high with a result unless bit 50 is 1, both format fields are 11, bits 48 and 49 are equal, and bits 55 and 47 are 0; the result value is the same as if the encoding were supported (signedness from bit 48, formats and saturate ignored).
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low after synchronous reset; `unsupported` is never high while `out_valid` is low; after reset `result` is 0.
- R10: In a cycle that follows one with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 64 | Instruction word |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| opnd_c | input | 32 | Operand C (lane source, addend or second comparand) |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Destination value |
| unsupported | output | 1 | Encoding is outside the fully handled subset |

## Verification
The hardest cases to reach are the ones where the two signedness controls disagree. The primary compare is unsigned while the secondary one is signed (or the other way round), and the operands sit right at the sign boundary. That is the only place where a swapped control bit changes the result. The bench gets there with a complete sweep: every secondary code, both max/min choices and all four signedness pairings, crossed with every combination of A, B and C drawn from a corner set of 0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and one mixed pattern. Each encoding bit outside the subset is then flipped on its own to show the flag rises while the value does not move.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int INSTR_W = 64;
    localparam int DATA_W  = 32;

    localparam logic [6:0] OPC_PATTERN = 7'b0011101;
    localparam logic [1:0] FMT_FULL    = 2'b11;

    typedef enum logic [2:0] {
        SEC_INS_HI16 = 3'd0,
        SEC_INS_LO16 = 3'd1,
        SEC_INS_B0   = 3'd2,
        SEC_INS_B2   = 3'd3,
        SEC_ADD      = 3'd4,
        SEC_MIN      = 3'd5,
        SEC_MAX      = 3'd6,
        SEC_PASS     = 3'd7
    } sec_op_e;

    typedef struct packed {
        logic    pick_max;
        logic    a_signed;
        logic    dst_signed;
        sec_op_e sec_op;
        logic    supported;
    } dec_t;

endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
    import dmx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic       opc_hit;
    logic       sat;
    logic       b_is_reg;
    logic       b_signed;
    logic       cc_write;
    logic [1:0] fmt_a;
    logic [1:0] fmt_b;
    logic       unused_fields;

    always_comb begin
        opc_hit    = (instr[63:57] == OPC_PATTERN);
        sat        = instr[55];
        b_is_reg   = instr[50];
        b_signed   = instr[49];
        cc_write   = instr[47];
        fmt_a      = instr[38:37];
        fmt_b      = instr[30:29];

        dec.pick_max   = instr[56];
        dec.dst_signed = instr[54];
        dec.sec_op     = sec_op_e'(instr[53:51]);
        dec.a_signed   = instr[48];
        dec.supported  = opc_hit && b_is_reg && !sat && !cc_write
                         && (fmt_a == FMT_FULL) && (fmt_b == FMT_FULL)
                         && (b_signed == instr[48]);
    end

    assign unused_fields = ^{instr[46:39], instr[36:31], instr[28:0]};

endmodule

// File: rtl/dmx_minmax.sv
module dmx_minmax #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sgn,
    input  logic         take_max,
    output logic [W-1:0] z
);

    logic [W:0] x_ext;
    logic [W:0] y_ext;
    logic       x_lt_y;

    always_comb begin
        x_ext  = {sgn & x[W-1], x};
        y_ext  = {sgn & y[W-1], y};
        x_lt_y = $signed(x_ext) < $signed(y_ext);
        z      = (take_max ^ x_lt_y) ? x : y;
    end

endmodule

// File: rtl/dmx_combine.sv
module dmx_combine
    import dmx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] prim,
    input  logic [W-1:0] opnd_c,
    input  sec_op_e      op,
    input  logic         dst_sgn,
    output logic [W-1:0] res
);

    localparam int HALF = W / 2;
    localparam int QUAR = W / 4;

    logic [W-1:0] mm_out;
    logic [W-1:0] ins_mask;
    logic [W-1:0] ins_val;
    int           lane_lo;
    int           lane_w;

    dmx_minmax #(.W(W)) u_second (
        .x        (prim),
        .y        (opnd_c),
        .sgn      (dst_sgn),
        .take_max (op == SEC_MAX),
        .z        (mm_out)
    );

    always_comb begin
        lane_lo = 0;
        lane_w  = HALF;
        case (op)
            SEC_INS_HI16: begin lane_lo = HALF; lane_w = HALF; end
            SEC_INS_LO16: begin lane_lo = 0;    lane_w = HALF; end
            SEC_INS_B0:   begin lane_lo = 0;    lane_w = QUAR; end
            SEC_INS_B2:   begin lane_lo = HALF; lane_w = QUAR; end
            default:      begin lane_lo = 0;    lane_w = HALF; end
        endcase
        ins_mask = ((W'(1) << lane_w) - W'(1)) << lane_lo;
        ins_val  = (opnd_c & ~ins_mask) | ((prim << lane_lo) & ins_mask);

        case (op)
            SEC_INS_HI16, SEC_INS_LO16,
            SEC_INS_B0, SEC_INS_B2: res = ins_val;
            SEC_ADD:                res = prim + opnd_c;
            SEC_MIN, SEC_MAX:       res = mm_out;
            default:                res = prim;
        endcase
    end

endmodule

// File: rtl/dual_minmax_unit.sv
module dual_minmax_unit
    import dmx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [W-1:0]       opnd_a,
    input  logic [W-1:0]       opnd_b,
    input  logic [W-1:0]       opnd_c,
    output logic               out_valid,
    output logic [W-1:0]       result,
    output logic               unsupported
);

    typedef struct packed {
        logic         vld;
        logic         unsup;
        logic [W-1:0] data;
    } stage_t;

    dec_t         dec;
    logic [W-1:0] prim_val;
    logic [W-1:0] final_val;
    stage_t       stage_d;
    stage_t       stage_q;

    dmx_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    dmx_minmax #(.W(W)) u_first (
        .x        (opnd_a),
        .y        (opnd_b),
        .sgn      (dec.a_signed),
        .take_max (dec.pick_max),
        .z        (prim_val)
    );

    dmx_combine #(.W(W)) u_combine (
        .prim    (prim_val),
        .opnd_c  (opnd_c),
        .op      (dec.sec_op),
        .dst_sgn (dec.dst_signed),
        .res     (final_val)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.vld   = in_valid;
        stage_d.unsup = 1'b0;
        if (in_valid) begin
            stage_d.unsup = ~dec.supported;
            stage_d.data  = final_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.vld;
    assign unsupported = stage_q.unsup;
    assign result      = stage_q.data;

endmodule

// File: rtl/dmx_checker.sv
module dmx_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] instr,
    input logic [31:0] opnd_c,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        unsupported
);

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_flag_qualified_R9: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> out_valid);

    assert_opc_miss_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[63:57] != 7'b0011101) |=> unsupported);

    assert_keep_low_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[53:51] == 3'd0) |=> result[15:0] == $past(opnd_c[15:0]));

    assert_keep_high_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[53:51] == 3'd1) |=> result[31:16] == $past(opnd_c[31:16]));

    assert_keep_b0_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[53:51] == 3'd2) |=> result[31:8] == $past(opnd_c[31:8]));

    assert_keep_b2_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[53:51] == 3'd3) |=>
            {result[31:24], result[15:0]} == $past({opnd_c[31:24], opnd_c[15:0]}));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

endmodule

bind dual_minmax_unit dmx_checker u_dmx_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .instr       (instr),
    .opnd_c      (opnd_c),
    .out_valid   (out_valid),
    .result      (result),
    .unsupported (unsupported)
);

// File: tb/tb_dual_minmax_unit.sv
module tb_dual_minmax_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] instr = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] opnd_c = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        unsupported;

    int checks = 0;
    int errors = 0;

    logic [31:0] corners [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF,
                                 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_89AB};

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_minmax_unit dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .instr       (instr),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .opnd_c      (opnd_c),
        .out_valid   (out_valid),
        .result      (result),
        .unsupported (unsupported)
    );

    function automatic logic [63:0] mk(logic [6:0] opc, logic mx, logic sat, logic ds,
                                       logic [2:0] sec, logic breg, logic bs, logic as_,
                                       logic cc, logic [1:0] fa, logic [1:0] fb);
        logic [63:0] w = '0;
        w[63:57] = opc; w[56] = mx; w[55] = sat; w[54] = ds; w[53:51] = sec;
        w[50] = breg; w[49] = bs; w[48] = as_; w[47] = cc;
        w[38:37] = fa; w[30:29] = fb;
        return w;
    endfunction

    function automatic logic [31:0] sel(logic [31:0] x, logic [31:0] y, logic sgn, logic mx);
        longint vx = sgn ? longint'($signed(x)) : longint'({32'b0, x});
        longint vy = sgn ? longint'($signed(y)) : longint'({32'b0, y});
        if (mx) return (vy > vx) ? y : x;
        return (vy < vx) ? y : x;
    endfunction

    function automatic logic [31:0] model(logic [63:0] w, logic [31:0] a,
                                          logic [31:0] b, logic [31:0] c);
        logic [31:0] p = sel(a, b, w[48], w[56]);
        case (w[53:51])
            3'd0:    return {p[15:0], c[15:0]};
            3'd1:    return {c[31:16], p[15:0]};
            3'd2:    return {c[31:8], p[7:0]};
            3'd3:    return {c[31:24], p[7:0], c[15:0]};
            3'd4:    return 32'((64'(p) + 64'(c)) % 64'h1_0000_0000);
            3'd5:    return sel(p, c, w[54], 1'b0);
            3'd6:    return sel(p, c, w[54], 1'b1);
            default: return p;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(logic [63:0] w, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        @(negedge clk);
        in_valid = 1'b1; instr = w; opnd_a = a; opnd_b = b; opnd_c = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_case(string tag, logic [63:0] w, logic [31:0] a, logic [31:0] b,
                           logic [31:0] c, logic exp_unsup);
        run(w, a, b, c);
        chk({tag, " value"}, result, model(w, a, b, c));
        chk({tag, " out_valid R9"}, 32'(out_valid), 32'd1);
        chk({tag, " unsupported R8"}, 32'(unsupported), 32'(exp_unsup));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] base;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 reset out_valid", 32'(out_valid), 32'd0);
        chk("R9 reset unsupported", 32'(unsupported), 32'd0);
        chk("R9 reset result", result, 32'd0);

        // R2 R3 R4 R5 R6 R7: full sweep over codes, controls and corner operands
        for (int sec = 0; sec < 8; sec++) begin
            for (int ctl = 0; ctl < 8; ctl++) begin
                for (int ia = 0; ia < 6; ia++) begin
                    for (int ib = 0; ib < 6; ib++) begin
                        for (int ic = 0; ic < 6; ic++) begin
                            logic [63:0] w;
                            string tag;
                            w = mk(7'b0011101, ctl[0], 1'b0, ctl[2], sec[2:0], 1'b1,
                                   ctl[1], ctl[1], 1'b0, 2'b11, 2'b11);
                            if (sec < 4) tag = "R2/R3/R4 merge";
                            else if (sec == 4) tag = "R3/R5 add";
                            else if (sec < 7) tag = "R3/R6 second minmax";
                            else tag = "R3/R7 pass";
                            do_case(tag, w, corners[ia], corners[ib], corners[ic], 1'b0);
                        end
                    end
                end
            end
        end

        // R2: bits outside the decoded fields do not change the value
        base = mk(7'b0011101, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 2'b11);
        run(base | 64'h0000_7F98_7FFF_FFFF ^ 64'h0000_0018_0000_0000,
            32'h8000_0000, 32'h0000_0005, 32'hFFFF_FFF0);
        chk("R2 dont-care bits", result, model(base, 32'h8000_0000, 32'h0000_0005, 32'hFFFF_FFF0));
        chk("R2 dont-care flag", 32'(unsupported), 32'd0);

        // R1: opcode mismatch, including the immediate conversion form
        do_case("R1 opcode 0011100",
                mk(7'b0011100, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11),
                32'h10, 32'h20, 32'h0, 1'b1);
        do_case("R1 opcode 0111101",
                mk(7'b0111101, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11),
                32'h10, 32'h20, 32'h3, 1'b1);

        // R8: each subset condition broken on its own, value still computed
        do_case("R8 immediate B",
                mk(7'b0011101, 1'b1, 1'b0, 1'b0, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 2'b11),
                32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1);
        do_case("R8 saturate",
                mk(7'b0011101, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11),
                32'hFFFF_FFFF, 32'h2, 32'hFFFF_FFFF, 1'b1);
        do_case("R8 cc write",
                mk(7'b0011101, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11),
                32'h7, 32'h3, 32'h0, 1'b1);
        do_case("R8 A format 16",
                mk(7'b0011101, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 2'b11),
                32'h7, 32'h3, 32'h0, 1'b1);
        do_case("R8 B format 8",
                mk(7'b0011101, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b01),
                32'h7, 32'h3, 32'h0, 1'b1);
        do_case("R8 signedness mismatch A signed",
                mk(7'b0011101, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 2'b11),
                32'h8000_0000, 32'h1, 32'h0, 1'b1);
        do_case("R8 signedness mismatch B signed",
                mk(7'b0011101, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 2'b11),
                32'h8000_0000, 32'h1, 32'h0, 1'b1);

        // R9 R10: idle cycles drop out_valid and hold result
        run(mk(7'b0011101, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11),
            32'h5, 32'h9, 32'h100);
        held = result;
        chk("R5 add before idle", held, 32'h109);
        opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h0; opnd_c = 32'hFFFF_FFFF;
        instr = mk(7'b0011100, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00);
        @(negedge clk);
        chk("R9 idle out_valid", 32'(out_valid), 32'd0);
        chk("R9 idle unsupported", 32'(unsupported), 32'd0);
        chk("R10 idle hold", result, held);
        @(negedge clk);
        chk("R10 idle hold second cycle", result, held);

        // R9: back-to-back issue keeps out_valid high on consecutive cycles
        @(negedge clk);
        in_valid = 1'b1;
        instr = mk(7'b0011101, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11);
        opnd_a = 32'h30; opnd_b = 32'h40; opnd_c = 32'h0;
        @(negedge clk);
        chk("R9 back-to-back first", result, 32'h30);
        chk("R9 back-to-back first valid", 32'(out_valid), 32'd1);
        opnd_a = 32'h50;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 back-to-back second", result, 32'h40);
        chk("R9 back-to-back second valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        chk("R9 back-to-back drop", 32'(out_valid), 32'd0);

        // R9: reset mid-stream clears the output register
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        chk("R9 reset clears valid", 32'(out_valid), 32'd0);
        chk("R9 reset clears result", result, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule